// File: doc/BRIEF.md
# Framed serial DAC input controller

This block is the digital front end of a single-channel serial-input DAC. A host writes to it over three wires: an active-low frame select, a serial clock and a data line. All three are brought into the fast system clock domain through two-flop synchronisers. The serial clock is then edge-detected, and one data bit is taken on each of its falling edges while the frame is open.

The output register is loaded only when the final falling edge of a fixed-length frame has been seen. That register holds a straight-binary code and a two-bit power-down mode, and it drives the converter core. A frame whose select rises before that edge is dropped and leaves the register untouched. Clock edges after the final one are ignored until the select has gone high and then low again.

From reset the output sits at zero scale in normal mode, and it stays there until the first complete frame arrives. The code width is a parameter. A 14-bit code uses a 16-clock frame, and a 16-bit code uses a 24-clock frame.

Top module: `sdac_front`

## Requirements
- R1: While `frame_n_i` is low, one bit of `sdata_i` is taken on each falling edge of `sclk_i`. The first bit taken is bit FRAME_W-1 of the frame word and the last is bit 0.
- R2: FRAME_W is 24 when CODE_W is 16 and 16 when CODE_W is 14. Word bits [FRAME_W-1:FRAME_W-2] are the power-down mode, the next CODE_W bits down are the code (MSB first), and any remaining low bits are ignored.
- R3: When the FRAME_W-th falling edge arrives, `code_o` and `pd_mode_o` take the new word's fields on the third rising system clock edge after the pin edge, and not before.
- R4: If `frame_n_i` rises before the FRAME_W-th falling edge has been seen, the partial word is discarded. The outputs keep their previous values and `update_o` does not pulse.
- R5: After reset, `code_o` is all zeros, `pd_mode_o` is 00, `conv_en_o` is 1 and `update_o` is 0. These values hold until the first complete frame.
- R6: Falling edges after the FRAME_W-th one, while `frame_n_i` stays low, change nothing. A new frame begins only after `frame_n_i` goes high and then low again.
- R7: `conv_en_o` is 1 when `pd_mode_o` is 00 (normal) and 0 for the modes 01, 10 and 11.
- R8: A rise of `frame_n_i` that reaches the pins at the same instant as the final falling edge still commits the word.
- R9: `update_o` is high for exactly one system clock cycle per committed frame, in the cycle where the new outputs first appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n_i | input | 1 | Active-low frame select, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous; data taken on its falling edge |
| sdata_i | input | 1 | Serial data, MSB first |
| code_o | output | CODE_W | Committed straight-binary code |
| pd_mode_o | output | 2 | Committed power-down mode, 00 is normal |
| conv_en_o | output | 1 | Converter enable, low in any power-down mode |
| update_o | output | 1 | One-cycle strobe when the output register loads |

## Verification
The close call is a frame-select rise and the final falling clock edge landing in the same synchronised cycle. Here the commit must win. The bench provokes this by driving both pins in the same time step, and expects the new code and mode along with one update pulse. The opposite case is set up by raising the select two system cycles before the final edge, and there the old outputs must survive with no pulse. Random frames mix in random abort points and extra trailing edges, and each result is checked against a bench model of the committed register.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } shift_state_e;

    localparam logic [1:0] PD_NORMAL = 2'b00;
    localparam int         MODE_W    = 2;

    function automatic int frame_len(input int code_w);
        return (code_w <= 14) ? 16 : 24;
    endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [STAGES:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {(STAGES+1){RESET_VAL}};
        end else begin
            stg_q <= {stg_q[STAGES-1:0], in_i};
        end
    end

    assign lvl_o  = stg_q[STAGES-1];
    assign prev_o = stg_q[STAGES];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
    import sdac_pkg::*;
#(
    parameter int FRAME_W = 24,
    parameter int KEEP_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_lvl_i,
    input  logic              sclk_fall_i,
    input  logic              sdata_i,
    output logic              commit_o,
    output logic [KEEP_W-1:0] word_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam int PAD_W = FRAME_W - KEEP_W;
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] KEEP_C = CNT_W'(KEEP_W);

    typedef struct packed {
        shift_state_e      state;
        logic [CNT_W-1:0]  cnt;
        logic [KEEP_W-1:0] sreg;
    } shift_t;

    shift_t cur_q, nxt_d;
    logic   commit_d;

    always_comb begin
        nxt_d    = cur_q;
        commit_d = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (!frame_lvl_i) begin
                    nxt_d.state = ST_SHIFT;
                    nxt_d.cnt   = '0;
                    nxt_d.sreg  = '0;
                    if (sclk_fall_i) begin
                        nxt_d.sreg = {{(KEEP_W-1){1'b0}}, sdata_i};
                        nxt_d.cnt  = CNT_W'(1);
                    end
                end
            end
            ST_SHIFT: begin
                if (sclk_fall_i && cur_q.cnt == LAST_C) begin
                    commit_d    = 1'b1;
                    nxt_d.state = ST_DONE;
                end else if (frame_lvl_i) begin
                    nxt_d.state = ST_IDLE;
                end else if (sclk_fall_i) begin
                    nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                    if (cur_q.cnt < KEEP_C) begin
                        nxt_d.sreg = {cur_q.sreg[KEEP_W-2:0], sdata_i};
                    end
                end
            end
            default: begin
                if (frame_lvl_i) begin
                    nxt_d.state = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, cnt: '0, sreg: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign commit_o = commit_d;

    generate
        if (PAD_W == 0) begin : g_no_pad
            assign word_o = {cur_q.sreg[KEEP_W-2:0], sdata_i};
        end else begin : g_pad
            assign word_o = cur_q.sreg;
        end
    endgenerate
endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int CODE_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n_i,
    input  logic              sclk_i,
    input  logic              sdata_i,
    output logic [CODE_W-1:0] code_o,
    output logic [1:0]        pd_mode_o,
    output logic              conv_en_o,
    output logic              update_o
);
    localparam int FRAME_W = frame_len(CODE_W);
    localparam int KEEP_W  = MODE_W + CODE_W;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [1:0]        mode;
        logic              conv_en;
        logic              update;
    } out_t;

    logic [2:0]        pin_lvl, pin_prev;
    logic              frame_lvl, sclk_fall, data_lvl;
    logic              commit;
    logic [KEEP_W-1:0] word;
    out_t              out_q, out_d;

    sdac_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_i   ({frame_n_i, sclk_i, sdata_i}),
        .lvl_o  (pin_lvl),
        .prev_o (pin_prev)
    );

    assign frame_lvl = pin_lvl[2];
    assign sclk_fall = pin_prev[1] & ~pin_lvl[1];
    assign data_lvl  = pin_lvl[0];

    sdac_shifter #(
        .FRAME_W (FRAME_W),
        .KEEP_W  (KEEP_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_lvl_i (frame_lvl),
        .sclk_fall_i (sclk_fall),
        .sdata_i     (data_lvl),
        .commit_o    (commit),
        .word_o      (word)
    );

    always_comb begin
        out_d        = out_q;
        out_d.update = 1'b0;
        if (commit) begin
            out_d.mode    = word[KEEP_W-1 -: 2];
            out_d.code    = word[CODE_W-1:0];
            out_d.conv_en = (word[KEEP_W-1 -: 2] == PD_NORMAL);
            out_d.update  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{code: '0, mode: PD_NORMAL, conv_en: 1'b1, update: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign code_o    = out_q.code;
    assign pd_mode_o = out_q.mode;
    assign conv_en_o = out_q.conv_en;
    assign update_o  = out_q.update;
endmodule

// File: rtl/sdac_front_checker.sv
module sdac_front_checker #(
    parameter int CODE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code_o,
    input logic [1:0]        pd_mode_o,
    input logic              conv_en_o,
    input logic              update_o,
    input logic              sclk_fall
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (update_o) seen_q <= 1'b1;
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);  // R9

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !update_o |-> ($stable(code_o) && $stable(pd_mode_o)));  // R4

    AST_COMMIT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> $past(sclk_fall));  // R3

    AST_ENABLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en_o == (pd_mode_o == 2'b00));  // R7

    AST_ZERO_UNTIL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && !update_o) |-> (code_o == '0 && pd_mode_o == 2'b00 && conv_en_o));  // R5
endmodule

bind sdac_front sdac_front_checker #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/sdac_front_bench.sv
`timescale 1ns/1ps
module sdac_front_bench;
    localparam int CODE_W = 16;
    localparam int FW     = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1, sclk = 1'b0, sdata = 1'b0;
    logic [CODE_W-1:0] code_o;
    logic [1:0] pd_mode_o;
    logic conv_en_o, update_o;

    int checks = 0, errors = 0, upd_cnt = 0, exp_upd = 0;
    logic [CODE_W-1:0] exp_code = '0;
    logic [1:0] exp_mode = 2'b00;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdac_front #(.CODE_W(CODE_W)) u_sdac_front (
        .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n), .sclk_i(sclk),
        .sdata_i(sdata), .code_o(code_o), .pd_mode_o(pd_mode_o),
        .conv_en_o(conv_en_o), .update_o(update_o)
    );

    always @(negedge clk) if (rst_n && update_o) upd_cnt++;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    function automatic bit commits(input int nedges, input int how);
        return (nedges > FW) || (nedges == FW && how != 2);
    endfunction

    // how: 0 normal close, 1 select rises with final edge, 2 select rises 2 cycles early, 3 latency probe
    task automatic frame(input logic [FW-1:0] w, input int nedges, input int how, input string tag);
        logic [CODE_W-1:0] old_code;
        old_code = code_o;
        frame_n = 1'b0;
        wclk(4);
        for (int i = 0; i < nedges; i++) begin
            sdata = (i < FW) ? w[FW-1-i] : 1'($urandom);
            sclk  = 1'b1;
            if (i == nedges - 1 && how == 2) begin
                wclk(2); frame_n = 1'b1; wclk(2); sclk = 1'b0; wclk(4);
            end else if (i == nedges - 1 && how == 1) begin
                wclk(4); sclk = 1'b0; frame_n = 1'b1; wclk(4);
            end else if (i == nedges - 1 && how == 3) begin
                wclk(4); sclk = 1'b0;
                @(posedge clk); @(posedge clk); @(negedge clk);
                check(code_o == old_code && !update_o, {tag, " R3 early"}, code_o, old_code);
                @(posedge clk); @(negedge clk);
                check(code_o == w[FW-3 -: CODE_W] && update_o, {tag, " R3 on time"}, code_o, w[FW-3 -: CODE_W]);
                wclk(2);
            end else begin
                wclk(4); sclk = 1'b0; wclk(4);
            end
        end
        wclk(4);
        frame_n = 1'b1;
        wclk(6);
        if (commits(nedges, how)) begin
            exp_code = w[FW-3 -: CODE_W];
            exp_mode = w[FW-1 -: 2];
            exp_upd++;
        end
        @(negedge clk);
        check(code_o == exp_code, {tag, " code"}, code_o, exp_code);
        check(pd_mode_o == exp_mode, {tag, " mode"}, pd_mode_o, exp_mode);
        check(conv_en_o == (exp_mode == 2'b00), {tag, " R7 enable"}, conv_en_o, exp_mode == 2'b00);
        check(upd_cnt == exp_upd, {tag, " R9 strobe count"}, upd_cnt, exp_upd);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1));
        wclk(3);
        @(negedge clk);
        check(code_o == '0 && pd_mode_o == 2'b00, "R5 reset outputs", {pd_mode_o, code_o}, 0);
        check(conv_en_o == 1'b1 && update_o == 1'b0, "R5 reset enable/strobe", {conv_en_o, update_o}, 2);
        rst_n = 1'b1;
        wclk(4);
        // short frame before any write: stays at zero scale
        frame(24'h3FFFFF, 10, 0, "R4 R5 short first frame");
        // full frame, normal mode, pad bits set to ones (ignored, R2)
        frame({2'b00, 16'hA5C3, 6'h3F}, FW, 3, "R1 R2 normal frame");
        // power-down modes
        frame({2'b01, 16'h1234, 6'h00}, FW, 0, "R7 mode 01");
        frame({2'b11, 16'hFFFF, 6'h15}, FW, 0, "R7 mode 11");
        frame({2'b00, 16'h0001, 6'h2A}, FW, 0, "R1 lsb only");
        // abort one edge short, and abort just before final edge
        frame({2'b10, 16'h5555, 6'h00}, FW - 1, 0, "R4 one short");
        frame({2'b10, 16'h6666, 6'h00}, FW, 2, "R4 rise before final");
        // simultaneous rise with final edge commits
        frame({2'b10, 16'h7777, 6'h01}, FW, 1, "R8 same instant");
        // trailing edges ignored
        frame({2'b00, 16'h8001, 6'h00}, FW + 8, 0, "R6 extra edges");
        frame({2'b01, 16'h9AB0, 6'h00}, FW + 3, 2, "R6 late rise");
        frame({2'b00, 16'h0F0F, 6'h00}, FW, 0, "R6 new frame after");
        for (int k = 0; k < 25; k++) begin
            logic [FW-1:0] w;
            int n, how;
            w   = FW'($urandom);
            n   = ($urandom_range(0, 3) == 0) ? $urandom_range(1, FW - 1) : FW + $urandom_range(0, 2);
            how = $urandom_range(0, 2);
            frame(w, n, how, "R1 R4 R8 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule